// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block controls an 8-pin bidirectional port for a small microcontroller. Each pin works as plain GPIO under four software registers: output data, direction, pull-up enable and open-drain select. A timer compare output, the two lines of a serial interface, an event output and an event input can take pins over from GPIO control. A simple register bus reaches the four registers. The bus has an address, write data, a write strobe and combinational read data.

For every pin the controller drives an output enable, an output value and a pull-up enable toward an abstract pad, and it reads back the pad level. Pad levels go through a two-flop synchronizer before they reach a register read or a peripheral input. When a peripheral owns a pin, the direction bit still picks what a read of the data register returns for that pin. The pull-up drops out automatically while a pin drives low. The open-drain option also covers the peripheral outputs.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the data, direction, pull-up and open-drain registers are all 0. Every padOe and padPu bit is 0, and a read at any address returns 0 until the synchronizer has carried a pad level through.
- R2: The registers sit at these addresses: data at 0, direction at 1, pull-up at 2 and open-drain at 3. The open-drain register holds bits 5:0, and bits 7:6 read as 0. A write with busWe high updates the register on that clock edge, and not before.
- R3: A GPIO pin whose direction bit is 1 and whose open-drain bit is 0 drives padOe=1 with padOut equal to its data bit. A pin whose direction bit is 0 has padOe=0.
- R4: A read of address 0 returns the data bit for pins whose direction bit is 1. For pins whose direction bit is 0 it returns the pad level, and a pad change shows up after the second rising clock edge.
- R5: While cmpEn is 1, pin 2 drives cmpOut whatever its direction bit. That direction bit then only selects the read source for bit 2 at address 0.
- R6: While sciTxEn or sciRxEn is 1, pin 1 drives sciTxd and pin 0 is never driven. sciRxd carries the synchronized pin 0 level. With both enables at 0, pins 1 and 0 return to register control.
- R7: While evtOutEn is 1, pin 3 drives evtOut whatever its direction bit.
- R8: While evtInEn is 1, pin 4 is never driven, even with its direction bit at 1. evtIn always carries the synchronized pin 4 level.
- R9: padPu follows the pull-up register, except on a pin that is actively driving low, where it is 0.
- R10: On pins 5 to 0 with the open-drain bit set, an output value of 1 gives padOe=0 and an output value of 0 drives low. This holds for GPIO outputs and for the compare, serial transmit and event outputs alike. Pins 7 and 6 are always push-pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe |
| busRdata | output | 8 | Combinational read data |
| cmpEn | input | 1 | Timer compare output enabled |
| cmpOut | input | 1 | Timer compare output level |
| sciTxEn | input | 1 | Serial transmitter enabled |
| sciRxEn | input | 1 | Serial receiver enabled |
| sciTxd | input | 1 | Serial transmit data |
| sciRxd | output | 1 | Synchronized serial receive data (pin 0) |
| evtOutEn | input | 1 | Event output enabled |
| evtOut | input | 1 | Event output level |
| evtInEn | input | 1 | Event input in use on pin 4 |
| evtIn | output | 1 | Synchronized event input (pin 4) |
| padIn | input | 8 | Pad levels |
| padOe | output | 8 | Pad output enables |
| padOut | output | 8 | Pad output values |
| padPu | output | 8 | Pad pull-up enables |

## Verification
A register write and a peripheral takeover can fall in the same cycle. The bench raises cmpEn, with a new cmpOut level, in the same cycle that it writes a new data value for pin 2. It checks that the pad follows the compare output at once, while a read of the data register shows the old latch before the edge and the new latch after it. The bench then drops cmpEn together with a second write, to confirm that the pin goes back to the freshly written latch value and not to a stale one.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_ODRN = 2'd3
  } regSelT;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrPull;
    logic   wrOdrn;
    logic   rdHit;
    regSelT rdSel;
  } ctrlStrobeT;

endpackage

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctrlStrobeT        strb
);

  localparam int REG_COUNT = 4;

  logic   inRange;
  regSelT sel;

  // Only the four lowest addresses decode; anything above is a miss.
  assign inRange = (32'(busAddr) < REG_COUNT);
  assign sel     = regSelT'(busAddr[1:0]);

  always_comb begin
    strb        = '0;
    strb.rdHit  = inRange;
    strb.rdSel  = sel;
    if (busWe && inRange) begin
      unique case (sel)
        SEL_DATA: strb.wrData = 1'b1;
        SEL_DIR:  strb.wrDir  = 1'b1;
        SEL_PULL: strb.wrPull = 1'b1;
        SEL_ODRN: strb.wrOdrn = 1'b1;
        default:  strb        = strb;
      endcase
    end
  end

endmodule

// File: rtl/gpio_mux_dp.sv
module gpio_mux_dp
  import gpio_mux_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int OD_W        = 6,
  parameter int SYNC_STAGES = 2,
  parameter int RX_PIN      = 0,
  parameter int TX_PIN      = 1,
  parameter int CMP_PIN     = 2,
  parameter int EVO_PIN     = 3,
  parameter int EVI_PIN     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  logic [PORT_W-1:0] busWdata,
  output logic [PORT_W-1:0] busRdata,
  input  logic              cmpEn,
  input  logic              cmpOut,
  input  logic              sciTxEn,
  input  logic              sciRxEn,
  input  logic              sciTxd,
  output logic              sciRxd,
  input  logic              evtOutEn,
  input  logic              evtOut,
  input  logic              evtInEn,
  output logic              evtIn,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padPu,
  output logic [PORT_W-1:0] latchQ,
  output logic [PORT_W-1:0] dirQ,
  output logic [PORT_W-1:0] pullQ,
  output logic [OD_W-1:0]   odrnQ
);

  logic              sciOn;
  logic [PORT_W-1:0] pinSync;
  logic [PORT_W-1:0] odSel;
  logic [PORT_W-1:0] muxVal;
  logic [PORT_W-1:0] muxDrv;
  logic [PORT_W-1:0] syncStg [SYNC_STAGES];

  assign sciOn = sciTxEn | sciRxEn;

  // Software registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '0;
      pullQ  <= '0;
      odrnQ  <= '0;
    end else begin
      if (strb.wrData) latchQ <= busWdata;
      if (strb.wrDir)  dirQ   <= busWdata;
      if (strb.wrPull) pullQ  <= busWdata;
      if (strb.wrOdrn) odrnQ  <= busWdata[OD_W-1:0];
    end
  end

  // Pad level synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncStg[s] <= '0;
    end else begin
      syncStg[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncStg[s] <= syncStg[s-1];
    end
  end

  assign pinSync = syncStg[SYNC_STAGES-1];
  assign sciRxd  = pinSync[RX_PIN];
  assign evtIn   = pinSync[EVI_PIN];

  // Per-pin ownership, open-drain and pull-up gating
  for (genvar g = 0; g < PORT_W; g++) begin : gPin
    if (g < OD_W) begin : gOdCap
      assign odSel[g] = odrnQ[g];
    end else begin : gPushPull
      assign odSel[g] = 1'b0;
    end

    always_comb begin
      muxVal[g] = latchQ[g];
      muxDrv[g] = dirQ[g];
      if (g == CMP_PIN && cmpEn) begin
        muxVal[g] = cmpOut;
        muxDrv[g] = 1'b1;
      end
      if (g == TX_PIN && sciOn) begin
        muxVal[g] = sciTxd;
        muxDrv[g] = 1'b1;
      end
      if (g == RX_PIN && sciOn) begin
        muxDrv[g] = 1'b0;
      end
      if (g == EVO_PIN && evtOutEn) begin
        muxVal[g] = evtOut;
        muxDrv[g] = 1'b1;
      end
      if (g == EVI_PIN && evtInEn) begin
        muxDrv[g] = 1'b0;
      end
    end

    assign padOut[g] = muxVal[g];
    assign padOe[g]  = muxDrv[g] & ~(odSel[g] & muxVal[g]);
    assign padPu[g]  = pullQ[g] & ~(padOe[g] & ~muxVal[g]);
  end

  // Register read mux
  always_comb begin
    busRdata = '0;
    if (strb.rdHit) begin
      unique case (strb.rdSel)
        SEL_DATA: busRdata = (dirQ & latchQ) | (~dirQ & pinSync);
        SEL_DIR:  busRdata = dirQ;
        SEL_PULL: busRdata = pullQ;
        SEL_ODRN: busRdata = PORT_W'(odrnQ);
        default:  busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int OD_W        = 6,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWdata,
  input  logic              busWe,
  output logic [PORT_W-1:0] busRdata,
  input  logic              cmpEn,
  input  logic              cmpOut,
  input  logic              sciTxEn,
  input  logic              sciRxEn,
  input  logic              sciTxd,
  output logic              sciRxd,
  input  logic              evtOutEn,
  input  logic              evtOut,
  input  logic              evtInEn,
  output logic              evtIn,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padPu
);

  ctrlStrobeT        strb;
  logic [PORT_W-1:0] latchQ;
  logic [PORT_W-1:0] dirQ;
  logic [PORT_W-1:0] pullQ;
  logic [OD_W-1:0]   odrnQ;

  gpio_mux_ctrl #(
    .ADDR_W (ADDR_W)
  ) ctrl_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb)
  );

  gpio_mux_dp #(
    .PORT_W      (PORT_W),
    .OD_W        (OD_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .cmpEn    (cmpEn),
    .cmpOut   (cmpOut),
    .sciTxEn  (sciTxEn),
    .sciRxEn  (sciRxEn),
    .sciTxd   (sciTxd),
    .sciRxd   (sciRxd),
    .evtOutEn (evtOutEn),
    .evtOut   (evtOut),
    .evtInEn  (evtInEn),
    .evtIn    (evtIn),
    .padIn    (padIn),
    .padOe    (padOe),
    .padOut   (padOut),
    .padPu    (padPu),
    .latchQ   (latchQ),
    .dirQ     (dirQ),
    .pullQ    (pullQ),
    .odrnQ    (odrnQ)
  );

endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int PORT_W  = 8,
  parameter int OD_W    = 6,
  parameter int ADDR_W  = 2,
  parameter int RX_PIN  = 0,
  parameter int CMP_PIN = 2,
  parameter int EVI_PIN = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [PORT_W-1:0] busWdata,
  input logic              busWe,
  input logic              cmpEn,
  input logic              cmpOut,
  input logic              sciTxEn,
  input logic              sciRxEn,
  input logic              evtInEn,
  input logic [PORT_W-1:0] padOe,
  input logic [PORT_W-1:0] padOut,
  input logic [PORT_W-1:0] padPu,
  input logic [PORT_W-1:0] latchQ,
  input logic [PORT_W-1:0] dirQ,
  input logic [OD_W-1:0]   odrnQ
);

  localparam int TOP_PIN = PORT_W - 1;

  logic [OD_W-1:0] drivenHigh;
  assign drivenHigh = padOe[OD_W-1:0] & padOut[OD_W-1:0];

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'(1)) |=> (dirQ == $past(busWdata)));

  // R3
  gpio_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOe[TOP_PIN] == dirQ[TOP_PIN]) && (!dirQ[TOP_PIN] || padOut[TOP_PIN] == latchQ[TOP_PIN]));

  // R5
  cmp_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpEn |-> (padOut[CMP_PIN] == cmpOut));

  // R6
  rx_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sciTxEn || sciRxEn) |-> !padOe[RX_PIN]);

  // R8
  evi_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtInEn |-> !padOe[EVI_PIN]);

  // R9
  pull_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padPu & padOe & ~padOut) == '0);

  // R10
  odrn_no_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drivenHigh & odrnQ) == '0);

endmodule

bind gpio_mux_port gpio_mux_port_chk #(
  .PORT_W (PORT_W),
  .OD_W   (OD_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busWe    (busWe),
  .cmpEn    (cmpEn),
  .cmpOut   (cmpOut),
  .sciTxEn  (sciTxEn),
  .sciRxEn  (sciRxEn),
  .evtInEn  (evtInEn),
  .padOe    (padOe),
  .padOut   (padOut),
  .padPu    (padPu),
  .latchQ   (latchQ),
  .dirQ     (dirQ),
  .odrnQ    (odrnQ)
);

// File: tb/gpio_mux_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mux_port_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWe = 1'b0;
  logic [7:0] busRdata;
  logic       cmpEn = 1'b0, cmpOut = 1'b0;
  logic       sciTxEn = 1'b0, sciRxEn = 1'b0, sciTxd = 1'b0;
  logic       sciRxd;
  logic       evtOutEn = 1'b0, evtOut = 1'b0, evtInEn = 1'b0;
  logic       evtIn;
  logic [7:0] padIn = 8'hA5;
  logic [7:0] padOe, padOut, padPu;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  gpio_mux_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .busRdata(busRdata), .cmpEn(cmpEn), .cmpOut(cmpOut), .sciTxEn(sciTxEn),
    .sciRxEn(sciRxEn), .sciTxd(sciTxd), .sciRxd(sciRxd), .evtOutEn(evtOutEn),
    .evtOut(evtOut), .evtInEn(evtInEn), .evtIn(evtIn), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .padPu(padPu)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  task automatic clearAll();
    cmpEn = 0; sciTxEn = 0; sciRxEn = 0; evtOutEn = 0; evtInEn = 0;
    writeReg(2'd0, 8'h00); writeReg(2'd1, 8'h00);
    writeReg(2'd2, 8'h00); writeReg(2'd3, 8'h00);
  endtask

  task automatic tReset();
    logic [7:0] r;
    for (int a = 0; a < 4; a++) begin
      readReg(2'(a), r);
      chk("R1 read after reset", r, 8'h00);
    end
    chk("R1 padOe after reset", padOe, 8'h00);
    chk("R1 padPu after reset", padPu, 8'h00);
  endtask

  task automatic tRegAccess();
    logic [7:0] r;
    @(negedge clk);
    busAddr = 2'd1; busWdata = 8'h3C; busWe = 1'b1;
    #0.5;
    chk("R2 dir unchanged before edge", busRdata, 8'h00);
    @(negedge clk);
    busWe = 1'b0;
    readReg(2'd1, r); chk("R2 dir readback", r, 8'h3C);
    writeReg(2'd3, 8'hFF);
    readReg(2'd3, r); chk("R2 open-drain upper bits zero", r, 8'h3F);
    writeReg(2'd2, 8'h81);
    readReg(2'd2, r); chk("R2 pull-up readback", r, 8'h81);
    clearAll();
  endtask

  task automatic tDirOut();
    writeReg(2'd0, 8'h5A);
    writeReg(2'd1, 8'hFF);
    chk("R3 all outputs enabled", padOe, 8'hFF);
    chk("R3 outputs follow latch", padOut, 8'h5A);
    writeReg(2'd1, 8'h0F);
    chk("R3 input pins released", padOe, 8'h0F);
    clearAll();
  endtask

  task automatic tReadSource();
    logic [7:0] r;
    writeReg(2'd0, 8'hAA);
    writeReg(2'd1, 8'hF0);
    padIn = 8'h00;
    repeat (3) @(negedge clk);
    padIn = 8'h5C;
    @(negedge clk);
    readReg(2'd0, r); chk("R4 one edge not yet visible", r, 8'hA0);
    @(negedge clk);
    readReg(2'd0, r); chk("R4 mixed latch and pin read", r, 8'hAC);
    clearAll();
  endtask

  task automatic tCompare();
    logic [7:0] r;
    writeReg(2'd0, 8'h04);
    padIn = 8'h00;
    cmpEn = 1; cmpOut = 0;
    #0.5;
    chk("R5 compare drives low", {6'b0, padOe[2], padOut[2]}, 8'h02);
    cmpOut = 1;
    #0.5;
    chk("R5 compare drives high", {6'b0, padOe[2], padOut[2]}, 8'h03);
    repeat (2) @(negedge clk);
    readReg(2'd0, r); chk("R5 dir 0 reads pin", r & 8'h04, 8'h00);
    writeReg(2'd1, 8'h04);
    readReg(2'd0, r); chk("R5 dir 1 reads latch", r & 8'h04, 8'h04);
    cmpEn = 0; cmpOut = 0;
    #0.5;
    chk("R5 back to gpio", {6'b0, padOe[2], padOut[2]}, 8'h03);
    clearAll();
  endtask

  task automatic tSerial();
    writeReg(2'd1, 8'h03);
    padIn = 8'h01;
    sciTxEn = 1; sciTxd = 1;
    #0.5;
    chk("R6 tx pin drives txd, rx released", padOe[1:0] & {2{1'b1}}, 8'h02);
    chk("R6 tx level", {7'b0, padOut[1]}, 8'h01);
    repeat (2) @(negedge clk);
    chk("R6 rxd synced high", {7'b0, sciRxd}, 8'h01);
    sciTxEn = 0; sciRxEn = 1; sciTxd = 0;
    #0.5;
    chk("R6 rx-only enable", {6'b0, padOe[1:0]}, 8'h02);
    sciRxEn = 0;
    #0.5;
    chk("R6 both off gpio", {6'b0, padOe[1:0]}, 8'h03);
    clearAll();
  endtask

  task automatic tEvents();
    evtOutEn = 1; evtOut = 1;
    #0.5;
    chk("R7 event output drives", {6'b0, padOe[3], padOut[3]}, 8'h03);
    evtOutEn = 0;
    writeReg(2'd0, 8'h10);
    writeReg(2'd1, 8'h10);
    evtInEn = 1;
    padIn = 8'h10;
    #0.5;
    chk("R8 event input never driven", {7'b0, padOe[4]}, 8'h00);
    repeat (2) @(negedge clk);
    chk("R8 event input synced", {7'b0, evtIn}, 8'h01);
    evtInEn = 0;
    #0.5;
    chk("R8 released back to gpio", {7'b0, padOe[4]}, 8'h01);
    clearAll();
  endtask

  task automatic tPullUp();
    writeReg(2'd2, 8'hFF);
    writeReg(2'd0, 8'h05);
    writeReg(2'd1, 8'h0F);
    chk("R9 pull drops on low drivers", padPu, 8'hF5);
    clearAll();
  endtask

  task automatic tOpenDrain();
    writeReg(2'd3, 8'h3F);
    writeReg(2'd0, 8'hC3);
    writeReg(2'd1, 8'hFF);
    chk("R10 open-drain enables", padOe, 8'hFC);
    cmpEn = 1; cmpOut = 1;
    #0.5;
    chk("R10 compare high released", {7'b0, padOe[2]}, 8'h00);
    cmpOut = 0;
    #0.5;
    chk("R10 compare low driven", {6'b0, padOe[2], padOut[2]}, 8'h02);
    clearAll();
  endtask

  task automatic tSameCycle();
    logic [7:0] r;
    writeReg(2'd1, 8'h04);
    @(negedge clk);
    busAddr = 2'd0; busWdata = 8'h04; busWe = 1'b1;
    cmpEn = 1; cmpOut = 1;
    #0.5;
    chk("R5 pad follows compare at once", {7'b0, padOut[2]}, 8'h01);
    chk("R2 latch read old before edge", busRdata & 8'h04, 8'h00);
    @(negedge clk);
    busWe = 1'b0;
    readReg(2'd0, r); chk("R2 latch read new after edge", r & 8'h04, 8'h04);
    @(negedge clk);
    busAddr = 2'd0; busWdata = 8'h00; busWe = 1'b1;
    cmpEn = 0;
    @(negedge clk);
    busWe = 1'b0;
    chk("R5 pin returns to fresh latch", {6'b0, padOe[2], padOut[2]}, 8'h02);
    clearAll();
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tRegAccess();
    tDirOut();
    tReadSource();
    tCompare();
    tSerial();
    tEvents();
    tPullUp();
    tOpenDrain();
    tSameCycle();
    finishRun();
  end

endmodule